// File: doc/BRIEF.md
# Inter-Module Call and Return Sequencer

This block sequences the three control-transfer instructions that move a thread between code modules: a call, the landing instruction that must sit at the call target, and the return. A call carries a 16-bit immediate. The block adds that immediate, scaled by the 4-byte instruction size, to the base of a shared trampoline area. It saves a two-word return record on a private hardware stack and redirects fetch to the computed address. The first instruction fetched at that address is then checked. If it does not decode as the landing instruction, the thread enters a sticky fault.

A return pops the newest record and sends fetch back to the saved address. It also presents the caller's thread id from that record. The stack has its own storage and is never addressed by loads or stores. Its fill level is exported only as status. A call on a full stack or a return on an empty stack raises a fault, and neither changes the stack. A fault holds until reset or until the clear strobe is given.

The decoder feeds the block one-cycle strobes. The block answers in the following cycle with a one-cycle redirect pulse and the next PC.

Top module: `modcall_unit`

## Requirements
- R1: A call strobe in the idle state with the stack not full makes `redirect_o` high for exactly the next cycle. In that cycle `next_pc_o` equals `tramp_base_i + ofs_i*4`, taken modulo 2^PC_W.
- R2: An accepted call pushes a record holding `pc_i + 4` and `tid_i`, and `stk_level_o` rises by one.
- R3: A call in the idle state when `stk_level_o` equals DEPTH (`stk_full_o` high) leaves the level unchanged and gives no redirect. The next cycle shows `fault_o` high with `fault_code_o` = 1 (overflow).
- R4: After an accepted call the block waits for a landing check. A check with `land_ok_i` high returns it to idle, where calls are accepted again. A check with `land_ok_i` low sets `fault_o` with `fault_code_o` = 3 (bad landing). The pushed record stays on the stack.
- R5: While the block waits for the landing check, call and return strobes are ignored: there is no redirect and no change of level.
- R6: A return in the idle state with a non-empty stack pops the newest record. In the next cycle `redirect_o` is high, `next_pc_o` is the saved return address, `ret_tid_o` is the saved thread id, and the level falls by one. Records come back in last-in, first-out order.
- R7: A return in the idle state on an empty stack sets `fault_o` with `fault_code_o` = 2 (underflow). The level stays 0 and there is no redirect.
- R8: In the fault state every call, return and landing strobe is ignored. The clear strobe returns the block to idle with `fault_code_o` = 0 in the next cycle, and the stack contents are kept.
- R9: When call and return strobes arrive together in the idle state, only the call is acted on.
- R10: A landing check in the idle state, and a clear strobe outside the fault state, have no effect on any output.
- R11: After reset the block is idle with no fault. `fault_code_o` is 0, the level is 0, `stk_empty_o` is 1, `stk_full_o` is 0, `redirect_o` is 0, and `next_pc_o` and `ret_tid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Decoded module-call strobe |
| ret_i | input | 1 | Decoded module-return strobe |
| land_chk_i | input | 1 | Strobe marking the first instruction fetched at a call target |
| land_ok_i | input | 1 | With `land_chk_i`: that instruction decodes as the landing instruction |
| clr_i | input | 1 | Leave the fault state |
| pc_i | input | PC_W | PC of the call instruction |
| tid_i | input | TID_W | Caller thread id |
| tramp_base_i | input | PC_W | Base address of the trampoline area |
| ofs_i | input | OFS_W | Call immediate (slot index) |
| next_pc_o | output | PC_W | Fetch target, valid while `redirect_o` is high |
| redirect_o | output | 1 | One-cycle fetch redirect pulse |
| ret_tid_o | output | TID_W | Caller thread id restored by the last return |
| fault_o | output | 1 | Block is in the fault state |
| fault_code_o | output | 2 | Fault cause: 0 none, 1 overflow, 2 underflow, 3 bad landing |
| stk_level_o | output | $clog2(DEPTH+1) | Number of records on the stack |
| stk_full_o | output | 1 | Stack holds DEPTH records |
| stk_empty_o | output | 1 | Stack holds no records |

## Verification
The bench fills the stack to its limit with offsets near 0xFFFF and a base close to the top of the address space. A wrong scale or a dropped carry would show up as a bad fetch target. A design that let a call through on a full stack would overwrite a record or wrap the level. The bench then unwinds all records: a design with an off-by-one top pointer would return the wrong address or thread id. Further cases are a return on an empty stack, call and return together, and strobes while the landing check is pending or during a fault. A design that wrongly acted on any of these would give a stray redirect pulse or move the level. A bad landing must leave the pushed record in place, so a design that silently popped it would disagree on the next return.

// File: rtl/modcall_pkg.sv
package modcall_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE  = 2'd0,
      SEQ_AWAIT = 2'd1,
      SEQ_FAULT = 2'd2
   } seq_state_e;

   typedef enum logic [1:0] {
      FLT_NONE      = 2'd0,
      FLT_OVERFLOW  = 2'd1,
      FLT_UNDERFLOW = 2'd2,
      FLT_BADLAND   = 2'd3
   } fault_code_e;

endpackage

// File: rtl/modcall_target.sv
module modcall_target #(
   parameter int PC_W      = 32,
   parameter int OFS_W     = 16,
   parameter int SLOT_LOG2 = 2
) (
   input  logic [PC_W-1:0]  pc_i,
   input  logic [PC_W-1:0]  base_i,
   input  logic [OFS_W-1:0] ofs_i,
   output logic [PC_W-1:0]  target_o,
   output logic [PC_W-1:0]  link_o
);
   localparam int SCALED_W = OFS_W + SLOT_LOG2;
   localparam logic [PC_W-1:0] SLOT_BYTES = PC_W'(1) << SLOT_LOG2;

   logic [SCALED_W-1:0] scaled;
   logic [PC_W-1:0]     scaled_ext;

   assign scaled = {ofs_i, {SLOT_LOG2{1'b0}}};

   generate
      if (PC_W > SCALED_W) begin : g_zext
         assign scaled_ext = {{(PC_W-SCALED_W){1'b0}}, scaled};
      end else begin : g_trunc
         assign scaled_ext = scaled[PC_W-1:0];
      end
   endgenerate

   assign target_o = base_i + scaled_ext;
   assign link_o   = pc_i + SLOT_BYTES;
endmodule

// File: rtl/modcall_stack.sv
module modcall_stack #(
   parameter int DEPTH = 16,
   parameter int PC_W  = 32,
   parameter int TID_W = 16
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          push_i,
   input  logic                          pop_i,
   input  logic [PC_W-1:0]               push_pc_i,
   input  logic [TID_W-1:0]              push_tid_i,
   output logic [PC_W-1:0]               top_pc_o,
   output logic [TID_W-1:0]              top_tid_o,
   output logic [$clog2(DEPTH+1)-1:0]    level_o,
   output logic                          full_o,
   output logic                          empty_o
);
   localparam int LVL_W = $clog2(DEPTH+1);
   localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

   logic [LVL_W-1:0] level_q;
   logic [PC_W-1:0]  slot_pc  [DEPTH];
   logic [TID_W-1:0] slot_tid [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         level_q <= '0;
      end else if (push_i && (level_q != LVL_MAX)) begin
         level_q <= level_q + 1'b1;
      end else if (pop_i && (level_q != '0)) begin
         level_q <= level_q - 1'b1;
      end
   end

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               slot_pc[g]  <= '0;
               slot_tid[g] <= '0;
            end else if (push_i && (level_q == LVL_W'(g))) begin
               slot_pc[g]  <= push_pc_i;
               slot_tid[g] <= push_tid_i;
            end
         end
      end
   endgenerate

   always_comb begin
      top_pc_o  = '0;
      top_tid_o = '0;
      for (int i = 0; i < DEPTH; i++) begin
         if (level_q == LVL_W'(i + 1)) begin
            top_pc_o  = slot_pc[i];
            top_tid_o = slot_tid[i];
         end
      end
   end

   assign level_o = level_q;
   assign full_o  = (level_q == LVL_MAX);
   assign empty_o = (level_q == '0);
endmodule

// File: rtl/modcall_seq.sv
module modcall_seq
   import modcall_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        call_i,
   input  logic        ret_i,
   input  logic        land_chk_i,
   input  logic        land_ok_i,
   input  logic        clr_i,
   input  logic        full_i,
   input  logic        empty_i,
   output logic        push_o,
   output logic        pop_o,
   output logic        take_call_o,
   output logic        take_ret_o,
   output seq_state_e  state_o,
   output fault_code_e code_o
);
   seq_state_e  state_q, state_d;
   fault_code_e code_q, code_d;

   always_comb begin
      state_d     = state_q;
      code_d      = code_q;
      push_o      = 1'b0;
      pop_o       = 1'b0;
      take_call_o = 1'b0;
      take_ret_o  = 1'b0;
      unique case (state_q)
         SEQ_IDLE: begin
            if (call_i) begin
               if (full_i) begin
                  state_d = SEQ_FAULT;
                  code_d  = FLT_OVERFLOW;
               end else begin
                  push_o      = 1'b1;
                  take_call_o = 1'b1;
                  state_d     = SEQ_AWAIT;
               end
            end else if (ret_i) begin
               if (empty_i) begin
                  state_d = SEQ_FAULT;
                  code_d  = FLT_UNDERFLOW;
               end else begin
                  pop_o      = 1'b1;
                  take_ret_o = 1'b1;
               end
            end
         end
         SEQ_AWAIT: begin
            if (land_chk_i) begin
               if (land_ok_i) begin
                  state_d = SEQ_IDLE;
               end else begin
                  state_d = SEQ_FAULT;
                  code_d  = FLT_BADLAND;
               end
            end
         end
         SEQ_FAULT: begin
            if (clr_i) begin
               state_d = SEQ_IDLE;
               code_d  = FLT_NONE;
            end
         end
         default: begin
            state_d = SEQ_IDLE;
            code_d  = FLT_NONE;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         code_q  <= FLT_NONE;
      end else begin
         state_q <= state_d;
         code_q  <= code_d;
      end
   end

   assign state_o = state_q;
   assign code_o  = code_q;
endmodule

// File: rtl/modcall_unit.sv
module modcall_unit
   import modcall_pkg::*;
#(
   parameter int DEPTH     = 16,
   parameter int PC_W      = 32,
   parameter int TID_W     = 16,
   parameter int OFS_W     = 16,
   parameter int SLOT_LOG2 = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       call_i,
   input  logic                       ret_i,
   input  logic                       land_chk_i,
   input  logic                       land_ok_i,
   input  logic                       clr_i,
   input  logic [PC_W-1:0]            pc_i,
   input  logic [TID_W-1:0]           tid_i,
   input  logic [PC_W-1:0]            tramp_base_i,
   input  logic [OFS_W-1:0]           ofs_i,
   output logic [PC_W-1:0]            next_pc_o,
   output logic                       redirect_o,
   output logic [TID_W-1:0]           ret_tid_o,
   output logic                       fault_o,
   output logic [1:0]                 fault_code_o,
   output logic [$clog2(DEPTH+1)-1:0] stk_level_o,
   output logic                       stk_full_o,
   output logic                       stk_empty_o
);
   localparam int LVL_W = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2) begin : g_chk_depth
         $error("modcall_unit: DEPTH must be at least 2");
      end
      if (PC_W < 8) begin : g_chk_pc
         $error("modcall_unit: PC_W must be at least 8");
      end
      if (OFS_W < 1 || TID_W < 1) begin : g_chk_fields
         $error("modcall_unit: OFS_W and TID_W must be positive");
      end
   endgenerate

   seq_state_e  seq_state;
   fault_code_e seq_code;
   logic        push, pop, take_call, take_ret;
   logic [PC_W-1:0]  target, link, top_pc;
   logic [TID_W-1:0] top_tid;
   logic [LVL_W-1:0] level;
   logic             full, empty;

   logic [PC_W-1:0]  next_pc_q;
   logic             redirect_q;
   logic [TID_W-1:0] ret_tid_q;

   modcall_target #(
      .PC_W(PC_W), .OFS_W(OFS_W), .SLOT_LOG2(SLOT_LOG2)
   ) u_target (
      .pc_i(pc_i), .base_i(tramp_base_i), .ofs_i(ofs_i),
      .target_o(target), .link_o(link)
   );

   modcall_stack #(
      .DEPTH(DEPTH), .PC_W(PC_W), .TID_W(TID_W)
   ) u_stack (
      .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop),
      .push_pc_i(link), .push_tid_i(tid_i),
      .top_pc_o(top_pc), .top_tid_o(top_tid),
      .level_o(level), .full_o(full), .empty_o(empty)
   );

   modcall_seq u_seq (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
      .land_chk_i(land_chk_i), .land_ok_i(land_ok_i), .clr_i(clr_i),
      .full_i(full), .empty_i(empty),
      .push_o(push), .pop_o(pop),
      .take_call_o(take_call), .take_ret_o(take_ret),
      .state_o(seq_state), .code_o(seq_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         next_pc_q  <= '0;
         redirect_q <= 1'b0;
         ret_tid_q  <= '0;
      end else begin
         redirect_q <= take_call | take_ret;
         if (take_call) begin
            next_pc_q <= target;
         end else if (take_ret) begin
            next_pc_q <= top_pc;
            ret_tid_q <= top_tid;
         end
      end
   end

   assign next_pc_o    = next_pc_q;
   assign redirect_o   = redirect_q;
   assign ret_tid_o    = ret_tid_q;
   assign fault_o      = (seq_state == SEQ_FAULT);
   assign fault_code_o = seq_code;
   assign stk_level_o  = level;
   assign stk_full_o   = full;
   assign stk_empty_o  = empty;
endmodule

// File: rtl/modcall_unit_chk.sv
module modcall_unit_chk #(
   parameter int DEPTH     = 16,
   parameter int PC_W      = 32,
   parameter int TID_W     = 16,
   parameter int OFS_W     = 16,
   parameter int SLOT_LOG2 = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       call_i,
   input logic                       ret_i,
   input logic                       land_chk_i,
   input logic                       land_ok_i,
   input logic                       clr_i,
   input logic [PC_W-1:0]            tramp_base_i,
   input logic [OFS_W-1:0]           ofs_i,
   input logic [PC_W-1:0]            next_pc_o,
   input logic                       redirect_o,
   input logic                       fault_o,
   input logic [1:0]                 fault_code_o,
   input logic [$clog2(DEPTH+1)-1:0] stk_level_o,
   input logic                       stk_full_o,
   input logic                       stk_empty_o,
   input logic [1:0]                 seq_state
);
   localparam int LVL_W = $clog2(DEPTH+1);

   logic idle, await_land;
   logic [PC_W-1:0] want_target;
   assign idle        = (seq_state == 2'd0);
   assign await_land  = (seq_state == 2'd1);
   assign want_target = tramp_base_i + (PC_W'(ofs_i) << SLOT_LOG2);

   p_call_target_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && call_i && !stk_full_o) |=> (redirect_o && next_pc_o == $past(want_target)));

   p_push_level_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && call_i && !stk_full_o) |=> (stk_level_o == $past(stk_level_o) + 1'b1));

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && call_i && stk_full_o) |=>
         (fault_o && fault_code_o == 2'd1 && $stable(stk_level_o) && !redirect_o));

   p_bad_landing_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (await_land && land_chk_i && !land_ok_i) |=> (fault_o && fault_code_o == 2'd3));

   p_await_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (await_land && !land_chk_i) |=> ($stable(stk_level_o) && !redirect_o && !fault_o));

   p_pop_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && ret_i && !call_i && !stk_empty_o) |=>
         (redirect_o && stk_level_o == $past(stk_level_o) - 1'b1));

   p_no_underflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && ret_i && !call_i && stk_empty_o) |=>
         (fault_o && fault_code_o == 2'd2 && stk_level_o == '0 && !redirect_o));

   p_fault_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_o && !clr_i) |=> (fault_o && $stable(stk_level_o) && !redirect_o));

   p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      stk_level_o <= LVL_W'(DEPTH));

   p_idle_land_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (idle && land_chk_i && !call_i && !ret_i) |=> (!fault_o && !redirect_o && $stable(stk_level_o)));
endmodule

bind modcall_unit modcall_unit_chk #(
   .DEPTH(DEPTH), .PC_W(PC_W), .TID_W(TID_W), .OFS_W(OFS_W), .SLOT_LOG2(SLOT_LOG2)
) u_chk (
   .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
   .land_chk_i(land_chk_i), .land_ok_i(land_ok_i), .clr_i(clr_i),
   .tramp_base_i(tramp_base_i), .ofs_i(ofs_i),
   .next_pc_o(next_pc_o), .redirect_o(redirect_o), .fault_o(fault_o),
   .fault_code_o(fault_code_o), .stk_level_o(stk_level_o),
   .stk_full_o(stk_full_o), .stk_empty_o(stk_empty_o), .seq_state(seq_state)
);

// File: tb/modcall_unit_tb.sv
module modcall_unit_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DEPTH = 16;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        call_i = 0, ret_i = 0, land_chk_i = 0, land_ok_i = 0, clr_i = 0;
   logic [31:0] pc_i = '0, tramp_base_i = '0;
   logic [15:0] tid_i = '0, ofs_i = '0;
   logic [31:0] next_pc_o;
   logic        redirect_o, fault_o, stk_full_o, stk_empty_o;
   logic [15:0] ret_tid_o;
   logic [1:0]  fault_code_o;
   logic [4:0]  stk_level_o;

   always #(CLK_PERIOD/2) clk = ~clk;

   modcall_unit #(.DEPTH(DEPTH)) u_dut (
      .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i),
      .land_chk_i(land_chk_i), .land_ok_i(land_ok_i), .clr_i(clr_i),
      .pc_i(pc_i), .tid_i(tid_i), .tramp_base_i(tramp_base_i), .ofs_i(ofs_i),
      .next_pc_o(next_pc_o), .redirect_o(redirect_o), .ret_tid_o(ret_tid_o),
      .fault_o(fault_o), .fault_code_o(fault_code_o), .stk_level_o(stk_level_o),
      .stk_full_o(stk_full_o), .stk_empty_o(stk_empty_o)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural reference: 0 idle, 1 awaiting landing, 2 fault
   int          m_state = 0;
   int          m_code = 0;
   logic [31:0] m_next = '0;
   logic [15:0] m_rtid = '0;
   bit          m_redir = 0;
   logic [31:0] q_pc[$];
   logic [15:0] q_tid[$];

   // operand values applied with the next strobe set
   logic [31:0] b_pc = '0, b_base = '0;
   logic [15:0] b_tid = '0, b_ofs = '0;

   task automatic model_step(bit c, bit r, bit l, bit ok, bit cl);
      m_redir = 0;
      case (m_state)
         0: if (c) begin
               if (q_pc.size() == DEPTH) begin m_state = 2; m_code = 1; end
               else begin
                  q_pc.push_back(b_pc + 32'd4);
                  q_tid.push_back(b_tid);
                  m_next  = b_base + {14'd0, b_ofs, 2'b00};
                  m_redir = 1;
                  m_state = 1;
               end
            end else if (r) begin
               if (q_pc.size() == 0) begin m_state = 2; m_code = 2; end
               else begin
                  m_next  = q_pc.pop_back();
                  m_rtid  = q_tid.pop_back();
                  m_redir = 1;
               end
            end
         1: if (l) begin
               if (ok) m_state = 0;
               else begin m_state = 2; m_code = 3; end
            end
         default: if (cl) begin m_state = 0; m_code = 0; end
      endcase
   endtask

   task automatic compare(string tag);
      int lvl;
      lvl = q_pc.size();
      checks++;
      if (next_pc_o !== m_next || redirect_o !== m_redir || ret_tid_o !== m_rtid ||
          fault_o !== (m_state == 2) || fault_code_o !== 2'(m_code) ||
          stk_level_o !== 5'(lvl) || stk_full_o !== (lvl == DEPTH) ||
          stk_empty_o !== (lvl == 0)) begin
         errors++;
         $display("FAIL %s: actual pc=%h rd=%b tid=%h f=%b c=%0d lvl=%0d fu=%b em=%b expected pc=%h rd=%b tid=%h f=%b c=%0d lvl=%0d",
                  tag, next_pc_o, redirect_o, ret_tid_o, fault_o, fault_code_o, stk_level_o,
                  stk_full_o, stk_empty_o, m_next, m_redir, m_rtid, (m_state == 2), m_code, lvl);
      end
   endtask

   task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic tick(bit c, bit r, bit l, bit ok, bit cl, string tag);
      @(negedge clk);
      call_i = c; ret_i = r; land_chk_i = l; land_ok_i = ok; clr_i = cl;
      pc_i = b_pc; tid_i = b_tid; tramp_base_i = b_base; ofs_i = b_ofs;
      @(posedge clk);
      model_step(c, r, l, ok, cl);
      #1;
      compare(tag);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R11 watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      compare("R11 reset state");

      // R1 R2: basic call, land, return
      b_pc = 32'h0000_0200; b_tid = 16'h0007; b_base = 32'h1000_0000; b_ofs = 16'h0010;
      tick(1, 0, 0, 0, 0, "R1 call");
      check_val("R1 target", next_pc_o, 32'h1000_0040);
      check_val("R1 redirect", {31'd0, redirect_o}, 32'd1);
      tick(0, 0, 0, 0, 0, "R1 single-cycle pulse");
      tick(0, 0, 1, 1, 0, "R4 good landing");
      tick(0, 1, 0, 0, 0, "R6 return");
      check_val("R2 saved link", next_pc_o, 32'h0000_0204);
      check_val("R6 restored tid", {16'd0, ret_tid_o}, 32'h0000_0007);

      // R2 R3: fill the stack, wrapping target
      b_base = 32'hFFFF_0000;
      for (int i = 0; i < DEPTH; i++) begin
         b_pc = 32'h1000 + 32'(i) * 8; b_tid = 16'(i + 1); b_ofs = 16'hFFFF - 16'(i);
         tick(1, 0, 0, 0, 0, "R2 push");
         if (i == 0) check_val("R1 wrapped target", next_pc_o, 32'h0002_FFFC);
         tick(0, 0, 1, 1, 0, "R4 landing");
      end
      check_val("R3 full flag", {31'd0, stk_full_o}, 32'd1);
      tick(1, 0, 0, 0, 0, "R3 overflow");
      check_val("R3 overflow code", {30'd0, fault_code_o}, 32'd1);
      tick(1, 1, 1, 0, 0, "R8 strobes in fault");
      tick(0, 0, 0, 0, 1, "R8 clear");

      // R6: unwind LIFO
      for (int k = 0; k < DEPTH; k++) begin
         tick(0, 1, 0, 0, 0, "R6 pop");
         check_val("R6 LIFO pc", next_pc_o, 32'h1000 + 32'(DEPTH - 1 - k) * 8 + 4);
      end
      tick(0, 1, 0, 0, 0, "R7 underflow");
      check_val("R7 underflow code", {30'd0, fault_code_o}, 32'd2);
      tick(0, 0, 0, 0, 1, "R8 clear after underflow");

      // R10: ignored strobes in idle
      tick(0, 0, 1, 0, 0, "R10 landing check in idle");
      tick(0, 0, 0, 0, 1, "R10 clear in idle");

      // R9, R5, R4 bad landing
      b_pc = 32'h0000_3000; b_tid = 16'h00AA; b_base = 32'h2000_0000; b_ofs = 16'h0001;
      tick(1, 1, 0, 0, 0, "R9 call and return together");
      check_val("R9 call wins", next_pc_o, 32'h2000_0004);
      tick(1, 0, 0, 0, 0, "R5 call while awaiting");
      tick(0, 1, 0, 0, 0, "R5 return while awaiting");
      tick(0, 0, 1, 0, 0, "R4 bad landing");
      check_val("R4 bad landing code", {30'd0, fault_code_o}, 32'd3);
      tick(0, 0, 0, 0, 1, "R8 clear keeps stack");
      tick(0, 1, 0, 0, 0, "R4 record kept after bad landing");
      check_val("R4 kept link", next_pc_o, 32'h0000_3004);

      // random mix, compared every clock
      for (int n = 0; n < 600; n++) begin
         b_pc = $urandom; b_tid = 16'($urandom); b_base = $urandom; b_ofs = 16'($urandom);
         tick(($urandom % 100) < 35, ($urandom % 100) < 30, ($urandom % 100) < 45,
              ($urandom % 100) < 85, ($urandom % 100) < 15, "R1/R6 random mix");
      end

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule